// File: doc/BRIEF.md
# Maskable Sticky Interrupt Aggregator

This block gathers single-cycle event pulses from three internal sources (a receiver, a synchronisation unit and a clock-crossing unit). Each event is latched into its own sticky pending flag. Every source also has an enable bit. A source is captured only while its enable is set, and it then drives one shared, active-low interrupt request line.

Software reaches the block through a single byte register at address 0x01 on a simple configuration port with write and read strobes. Pending flags are read-only. The only way to discard a pending flag is to write its enable bit to 0. That write clears the flag and also blocks further captures from that source until the enable is written back to 1. There is no separate acknowledge register.

Top module: `evt_irq_collector`

## Requirements
- R1: The register at address 0x01 reads as follows. Bit 7 is receiver pending, bit 6 is sync pending and bit 5 is crossing pending. Bit 3 is receiver enable, bit 2 is sync enable and bit 1 is crossing enable. Bits 4 and 0 always read 0. Event input `src_evt[2]` is the receiver, `[1]` is sync and `[0]` is crossing.
- R2: While `rst_n` is low, and after it is released, all pending flags and all enables are 0, and `irq_n` is 1.
- R3: A source event sets that source's pending flag at the next clock edge only if the enable bit already holds 1 before that edge. An event that arrives while the enable is 0 leaves no trace.
- R4: A pending flag stays set across later cycles until its enable is written to 0 or reset is applied.
- R5: Writing 0 to an enable bit at address 0x01 clears that source's pending flag and its enable at the next edge.
- R6: Write data on the pending bits (7..5) and on the reserved bits (4, 0) has no effect on any state.
- R7: `irq_n` is 0 exactly while at least one source has both its pending flag and its enable set, and is 1 otherwise. It follows state with no extra delay.
- R8: If a source event and a write of 0 to that source's enable occur in the same cycle, the flag ends up cleared.
- R9: Writes to any address other than 0x01 change nothing. `cfg_rdata` is 0 unless `cfg_rd` is high and `cfg_addr` is 0x01.
- R10: Writing 1 to an enable that is already 1 keeps its pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_evt | input | 3 | Event pulses: [2] receiver, [1] sync, [0] crossing |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data, combinational, 0 when not selected |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Suppose a pending flag or an enable bit holds a wrong value. Because the register read is combinational, that error shows on the read byte in the same cycle. It also shows on `irq_n` in the same cycle whenever it changes whether any enabled source is pending. The bench therefore compares the full read byte and `irq_n` against its model every cycle. A lost capture, a missed clear or a wrong priority between clear and event is caught one cycle after the edge that caused it. Stimulus covers directed corner cases and a long pseudo-random mix of events and writes.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned STAT_LSB = 5;
  localparam int unsigned EN_LSB   = 1;
  localparam logic [ADDR_W-1:0] IRQ_REG_ADDR = 5'h01;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [DATA_W-1:0]  reg_byte_t;

  // Place pending flags and enables into the register byte; other bits 0.
  function automatic reg_byte_t pack_reg(input src_vec_t flags, input src_vec_t ens);
    reg_byte_t b;
    b = '0;
    b[STAT_LSB +: NUM_SRC] = flags;
    b[EN_LSB   +: NUM_SRC] = ens;
    return b;
  endfunction

  // Extract the enable field from written data.
  function automatic src_vec_t unpack_en(input reg_byte_t b);
    return b[EN_LSB +: NUM_SRC];
  endfunction
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic wr_hit,
  input  logic wr_en_bit,
  output logic en_q,
  output logic flag_q,
  output logic capture,
  output logic clear
);
  // Clear wins over a same-cycle event; capture uses the enable held now.
  assign clear   = wr_hit & ~wr_en_bit;
  assign capture = evt & en_q & ~clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_hit) en_q <= wr_en_bit;
      if (clear)        flag_q <= 1'b0;
      else if (capture) flag_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irqagg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = IRQ_REG_ADDR
) (
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  reg_byte_t         cfg_wdata,
  input  src_vec_t          flags,
  input  src_vec_t          ens,
  output logic              wr_hit,
  output src_vec_t          wr_en_bits,
  output reg_byte_t         cfg_rdata
);
  logic sel;
  assign sel        = (cfg_addr == REG_ADDR);
  assign wr_hit     = cfg_wr & sel;
  assign wr_en_bits = unpack_en(cfg_wdata);
  assign cfg_rdata  = (cfg_rd && sel) ? pack_reg(flags, ens) : '0;
endmodule

// File: rtl/evt_irq_collector.sv
module evt_irq_collector
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              irq_n
);
  logic     wr_hit;
  src_vec_t wr_en_bits;
  src_vec_t en_q;
  src_vec_t flag_q;
  src_vec_t capture;
  src_vec_t clear;
  src_vec_t active;

  irq_reg_port #(.REG_ADDR(IRQ_REG_ADDR)) u_port (
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .flags     (flag_q),
    .ens       (en_q),
    .wr_hit    (wr_hit),
    .wr_en_bits(wr_en_bits),
    .cfg_rdata (cfg_rdata)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (src_evt[i]),
      .wr_hit   (wr_hit),
      .wr_en_bit(wr_en_bits[i]),
      .en_q     (en_q[i]),
      .flag_q   (flag_q[i]),
      .capture  (capture[i]),
      .clear    (clear[i])
    );
  end

  assign active = flag_q & en_q;
  assign irq_n  = ~(|active);
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_SRC-1:0] src_evt,
  input logic              wr_hit,
  input logic [NUM_SRC-1:0] wr_en_bits,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] flag_q,
  input logic              cfg_rd,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              irq_n
);
  assert_flag_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~en_q) == '0);

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_evt & en_q & ~({NUM_SRC{wr_hit}} & ~wr_en_bits)) != '0) |=>
    ((flag_q & $past(src_evt & en_q)) != '0));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((flag_q & ~$past(wr_en_bits)) == '0));

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == (flag_q == '0));

  assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rd || cfg_addr != IRQ_REG_ADDR) |-> cfg_rdata == '0);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[4] == 1'b0) && (cfg_rdata[0] == 1'b0));
endmodule

bind evt_irq_collector irqagg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_evt   (src_evt),
  .wr_hit    (wr_hit),
  .wr_en_bits(wr_en_bits),
  .en_q      (en_q),
  .flag_q    (flag_q),
  .cfg_rd    (cfg_rd),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .irq_n     (irq_n)
);

// File: tb/evt_irq_collector_tb.sv
module evt_irq_collector_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_evt = '0;
  logic       cfg_wr = 1'b0;
  logic       cfg_rd = 1'b1;
  logic [4:0] cfg_addr = 5'h01;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Model state: index 2 receiver, 1 sync, 0 crossing
  int m_flag[3];
  int m_en[3];

  always #2 clk = ~clk;

  evt_irq_collector u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .cfg_wr(cfg_wr),
    .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_n(irq_n)
  );

  function automatic int exp_byte();
    int v = 0;
    if (cfg_rd && cfg_addr == 5'd1)
      for (int i = 0; i < 3; i++) v += m_flag[i] * (32 << i) + m_en[i] * (2 << i);
    return v;
  endfunction

  function automatic int exp_irq();
    for (int i = 0; i < 3; i++) if (m_flag[i] != 0 && m_en[i] != 0) return 0;
    return 1;
  endfunction

  // Apply inputs at negedge, compare, then advance the model across the edge.
  task automatic step(input logic r, input logic [2:0] ev, input logic wr,
                      input logic [4:0] ad, input logic [7:0] wd, input logic rd,
                      input string tag);
    @(negedge clk);
    rst_n = r; src_evt = ev; cfg_wr = wr; cfg_addr = ad; cfg_wdata = wd; cfg_rd = rd;
    #1;
    n_cmp++;
    if (int'(cfg_rdata) != exp_byte() || int'(irq_n) != exp_irq()) begin
      n_bad++;
      $display("FAIL %s: rdata=%02h irq_n=%0d expected rdata=%02h irq_n=%0d",
               tag, cfg_rdata, irq_n, exp_byte(), exp_irq());
    end
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      if (!r) begin m_flag[i] = 0; m_en[i] = 0; end
      else begin
        bit hit = wr && ad == 5'd1;
        if (hit && !wd[1+i]) m_flag[i] = 0;
        else if (ev[i] && m_en[i] != 0) m_flag[i] = 1;
        if (hit) m_en[i] = wd[1+i];
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1, 3'b000, 0, 5'd1, 8'h00, 1, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 3; i++) begin m_flag[i] = 0; m_en[i] = 0; end
    // R2 reset state, events during reset ignored
    step(0, 3'b111, 1, 5'd1, 8'hFF, 1, "R2 in reset");
    step(0, 3'b111, 0, 5'd1, 8'h00, 1, "R2 in reset");
    idle(2, "R2 after reset");
    // R3 events while disabled leave nothing
    step(1, 3'b111, 0, 5'd1, 8'h00, 1, "R3 disabled event");
    idle(1, "R3 no capture");
    // R3 enable written together with event: not captured
    step(1, 3'b111, 1, 5'd1, 8'h0E, 1, "R3 enable write");
    idle(1, "R3 same-cycle enable");
    // R1/R3 capture each source separately
    step(1, 3'b100, 0, 5'd1, 8'h00, 1, "R3 receiver event");
    idle(1, "R1 receiver bit7");
    step(1, 3'b010, 0, 5'd1, 8'h00, 1, "R3 sync event");
    step(1, 3'b001, 0, 5'd1, 8'h00, 1, "R1 sync bit6");
    idle(3, "R4 sticky R7 irq low");
    // R6 status and reserved bits written as 1 ignored
    step(1, 3'b000, 1, 5'd1, 8'hFF, 1, "R6 write ones");
    idle(1, "R6 unchanged");
    // R10 rewriting 1 keeps flags
    step(1, 3'b000, 1, 5'd1, 8'h0E, 1, "R10 rewrite one");
    idle(1, "R10 flags kept");
    // R9 write of zeros elsewhere, reads gated
    step(1, 3'b000, 1, 5'd2, 8'h00, 1, "R9 other addr write");
    idle(1, "R9 unchanged");
    step(1, 3'b000, 0, 5'd1, 8'h00, 0, "R9 rd low");
    step(1, 3'b000, 0, 5'd3, 8'h00, 1, "R9 other addr read");
    // R5 clear receiver only
    step(1, 3'b000, 1, 5'd1, 8'h06, 1, "R5 clear receiver");
    idle(1, "R5 receiver cleared");
    step(1, 3'b100, 0, 5'd1, 8'h00, 1, "R5 capture blocked");
    idle(1, "R5 still clear");
    // R8 clear versus same-cycle event on sync
    step(1, 3'b010, 1, 5'd1, 8'h02, 1, "R8 clear with event");
    idle(1, "R8 cleared");
    // R7 clear last source, irq releases
    step(1, 3'b000, 1, 5'd1, 8'h00, 1, "R7 clear all");
    idle(2, "R7 irq high");
    // Mixed pseudo-random traffic, R3 R4 R5 R7 R8
    step(1, 3'b000, 1, 5'd1, 8'h0E, 1, "R3 re-enable");
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] wd;
      logic [4:0] ad;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wd = lfsr[7:0] | 8'h0E;
      if (lfsr[9:8] == 2'b00) wd = wd & ~(8'h02 << lfsr[12:11] % 3);
      ad = lfsr[14] ? 5'd1 : {2'b00, lfsr[13:11]};
      step(lfsr[15:4] != 12'h000, lfsr[6:4], lfsr[10] & lfsr[3], ad, wd,
           lfsr[2] | lfsr[1], "R4 R5 R7 R8 random");
    end
    idle(2, "R2 R7 final");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule